// File: doc/BRIEF.md
# Multi-Channel Compare System Timer

This block is a free-running system timer. A single 32-bit up-counter advances once every N module clocks, where N runs from 1 to 256 and is chosen by an 8-bit prescale field. Four compare channels watch this one counter. Each channel has its own compare value, its own enable and its own sticky interrupt flag. An enabled channel sets its flag whenever the counter equals its compare value. Software clears a flag by writing a one to it. The counter is never reloaded by a match, so an event comes back each time the counter returns to the same value. To stop further events, software disables the channel.

Software controls the block through a small word-addressed register interface with single-cycle writes and combinational reads. A global run bit gates counting. A freeze bit makes the counter and prescaler hold while the debug-halt input is high. Software can read the counter at any time and can write to it to load a new value.

Register map (word address: contents):
- 0: control. Bit 0 is run, bit 1 is freeze, bits 15:8 are the prescale field P.
- 1: counter.
- 2: channel enables, bits 3:0.
- 3: channel flags, bits 3:0, write-one-to-clear.
- 4 to 7: compare registers of channels 0 to 3.

Top module: `sys_cmp_timer`

## Requirements
- R1: After reset, the control, counter, enable, flag and compare registers all read zero, and all irq outputs are low.
- R2: While run (control bit 0) is 1 and no freeze applies, the counter increments by one every P+1 clocks. P is control bits 15:8.
- R3: The counter rolls over from 0xFFFFFFFF to 0.
- R4: While freeze (control bit 1) is 1 and debug_halt is high, the counter and the prescaler hold. With freeze at 0, debug_halt has no effect.
- R5: While run is 0 the counter holds. A write to address 1 loads the counter and restarts the prescale phase, whatever the state of run.
- R6: An enabled channel whose compare value equals the counter sets its flag (address 3, bit i) on the next clock. The match recurs whenever the counter again holds that value.
- R7: A disabled channel never sets its flag. Disabling a channel does not clear a flag that is already set.
- R8: A write to address 3 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 untouched. If a clear and a match occur in the same cycle, the flag stays set.
- R9: irq[i] is high exactly when flag i and enable i are both 1.
- R10: Writes to the compare or enable registers never pause, reset or otherwise alter the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| debug_halt | input | 1 | Debug halt request |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 4 | Per-channel interrupt levels |

## Verification
The counter is run with prescale values of 0, 2 and 3, so that stepping on every clock can be told apart from an off-by-one in the prescale divide. The counter is loaded just below all-ones to exercise the rollover. The compare tests place a match just after the rollover and then repeat it by reloading the counter. This separates a sticky, recurring flag from a flag that fires once or needs re-arming. Three cases separate the gating of the enable from the masking of the output: a disabled channel passing its match, a channel disabled while its flag is pending, and a clear issued while the match is still present. Two freeze patterns are applied, halt with freeze set and halt with freeze clear, to show that the hold depends on both signals together.

// File: rtl/sys_cmp_timer.sv
module sys_cmp_timer #(
  parameter int CW  = 32,
  parameter int NCH = 4,
  parameter int PW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          debug_halt,
  input  logic          bus_wr,
  input  logic [3:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [NCH-1:0] irq
);
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_CNT  = 4'd1;
  localparam logic [3:0] A_EN   = 4'd2;
  localparam logic [3:0] A_FLG  = 4'd3;
  localparam logic [3:0] A_CMP  = 4'd4;

  logic          run, frz;
  logic [PW-1:0] presc, phase;
  logic [CW-1:0] cnt;
  logic [NCH-1:0] en, flg, hit;
  logic [NCH-1:0][CW-1:0] cmp;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_cnt  = bus_wr && bus_addr == A_CNT;
  wire wr_en   = bus_wr && bus_addr == A_EN;
  wire wr_flg  = bus_wr && bus_addr == A_FLG;
  wire active  = run && !(frz && debug_halt);
  wire step    = active && phase == presc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      frz   <= 1'b0;
      presc <= '0;
    end else if (wr_ctrl) begin
      run   <= bus_wdata[0];
      frz   <= bus_wdata[1];
      presc <= bus_wdata[8 +: PW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= '0;
    end else if (wr_cnt) begin
      cnt   <= bus_wdata;
      phase <= '0;
    end else if (step) begin
      cnt   <= cnt + 1'b1;
      phase <= '0;
    end else if (active) begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else if (wr_en) en <= bus_wdata[NCH-1:0];
  end

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      assign hit[i] = en[i] && cnt == cmp[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp[i] <= '0;
        else if (bus_wr && bus_addr == A_CMP + 4'(i)) cmp[i] <= bus_wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg[i] <= 1'b0;
        else flg[i] <= (flg[i] && !(wr_flg && bus_wdata[i])) || hit[i];
      end

      assign irq[i] = flg[i] && en[i];

      p_no_set_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[i] && !flg[i]) |=> !flg[i]);
      p_disable_keeps_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flg[i] && !(wr_flg && bus_wdata[i])) |=> flg[i]);
      p_match_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en[i] && cnt == cmp[i]) |=> flg[i]);
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = CW'({presc, 6'b0, frz, run});
      A_CNT:   bus_rdata = cnt;
      A_EN:    bus_rdata = CW'(en);
      A_FLG:   bus_rdata = CW'(flg);
      default: if (bus_addr >= A_CMP && bus_addr < A_CMP + 4'(NCH))
                 bus_rdata = cmp[bus_addr - A_CMP];
    endcase
  end

  p_freeze_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && debug_halt && !wr_cnt && !wr_ctrl) |=> $stable(cnt));
  p_stopped_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt && !wr_ctrl) |=> $stable(cnt));
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(bus_wdata));
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/sim_sys_cmp_timer.sv
module sim_sys_cmp_timer;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0, debug_halt = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] irq;

  sys_cmp_timer u0 (.clk, .rst_n, .debug_halt, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq);

  always #(PER/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  bit m_run, m_frz;
  int unsigned m_p, m_ph, m_cnt;
  bit [3:0] m_en, m_flg;
  int unsigned m_cmp [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_frz = 0; m_p = 0; m_ph = 0; m_cnt = 0; m_en = 0; m_flg = 0;
      foreach (m_cmp[k]) m_cmp[k] = 0;
    end else begin
      bit [3:0] hitv, clr;
      bit go;
      for (int k = 0; k < 4; k++) hitv[k] = m_en[k] && (m_cnt == m_cmp[k]);
      clr = (bus_wr && bus_addr == 3) ? bus_wdata[3:0] : 4'h0;
      m_flg = (m_flg & ~clr) | hitv;
      go = m_run && !(m_frz && debug_halt);
      if (bus_wr && bus_addr == 1) begin m_cnt = bus_wdata; m_ph = 0; end
      else if (go) begin
        if (m_ph == m_p) begin m_ph = 0; m_cnt = m_cnt + 1; end
        else m_ph = m_ph + 1;
      end
      if (bus_wr && bus_addr == 0) begin
        m_run = bus_wdata[0]; m_frz = bus_wdata[1]; m_p = bus_wdata[15:8];
      end
      if (bus_wr && bus_addr == 2) m_en = bus_wdata[3:0];
      if (bus_wr && bus_addr >= 4 && bus_addr < 8) m_cmp[bus_addr-4] = bus_wdata;
    end
  end

  function automatic logic [31:0] mreg(input logic [3:0] a);
    case (a)
      0: return {16'h0, m_p[7:0], 6'h0, m_frz, m_run};
      1: return m_cnt;
      2: return {28'h0, m_en};
      3: return {28'h0, m_flg};
      default: return (a < 8) ? m_cmp[a-4] : 32'h0;
    endcase
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    tests++;
    if (irq !== (m_flg & m_en)) begin
      fails++;
      $display("FAIL R9 irq actual=%h expected=%h", irq, m_flg & m_en);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    @(negedge clk); bus_addr = a; #1;
    tests++;
    if (bus_rdata !== mreg(a)) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, mreg(a));
    end
  endtask

  task automatic rd_lit(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_addr = a; #1;
    tests++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, e);
    end
  endtask

  initial begin
    #(PER*150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    for (int a = 0; a < 8; a++) begin
      bus_addr = a[3:0]; #1;
      tests++;
      if (bus_rdata !== 0 || irq !== 0) begin
        fails++;
        $display("FAIL R1 addr=%0d actual=%h expected=0", a, bus_rdata);
      end
    end
    idle(3); rst_n = 1;
    for (int a = 0; a < 8; a++) rd_lit(a[3:0], 32'h0, "R1");

    wr(0, 32'h0301); idle(17); rd(1, "R2");
    wr(1, 0); idle(8); rd_lit(1, 32'd2, "R2");
    wr(0, 32'h0201); idle(11); rd(1, "R2");

    wr(0, 32'h0001); wr(4, 32'd1); wr(2, 32'h1);
    wr(1, 32'hFFFF_FFFD); idle(5); rd(1, "R3");
    rd(3, "R6");
    wr(3, 32'h1); rd(3, "R8");
    wr(1, 32'h0); idle(3); rd(3, "R6 recur");
    wr(3, 32'h0); rd(3, "R8 zero bits");
    wr(3, 32'h1);

    wr(5, 32'h40); wr(1, 32'h3E); idle(5); rd(3, "R7 disabled");
    wr(2, 32'h3); wr(1, 32'h3E); idle(5); rd(3, "R6 ch1");
    wr(2, 32'h1); rd(3, "R7 pending kept");

    wr(0, 32'h0003); debug_halt = 1; idle(3); rd(1, "R4"); idle(4); rd(1, "R4 hold");
    wr(0, 32'h0001); idle(5); rd(1, "R4 no freeze");
    debug_halt = 0;

    wr(0, 32'h0201); wr(6, 32'h1234); wr(2, 32'h5); wr(7, 32'h99); idle(2); rd(1, "R10");

    wr(0, 32'h0000); wr(1, 32'h10); idle(4); rd_lit(1, 32'h10, "R5");
    wr(4, 32'h10); wr(3, 32'hF); rd(3, "R8 clear vs match");
    wr(4, 32'h11); wr(3, 32'hF); rd(3, "R8 cleared");
    wr(1, 32'hABCD_0000); rd_lit(1, 32'hABCD_0000, "R5 load");

    idle(2); done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule